// File: doc/BRIEF.md
# I2C EEPROM page-write receiver

This block is the write side of a serial-memory slave on an I2C bus. A bit-level front end, not part of this block, turns the SDA/SCL waveforms into single-cycle event strobes: a START condition, a STOP condition, and a completed 8-bit byte. For every byte the front end hands over, the receiver answers one cycle later with a decision on whether to pull the acknowledge slot low.

A write frame opens with START. The first byte is the 7-bit device address followed by the direction bit. The next byte is the word address. Up to eight data bytes follow, each stored in a page buffer at an offset that advances and wraps inside an aligned 8-byte page. A STOP after at least one accepted data byte produces a one-cycle commit pulse. The pulse carries the page base address, a per-byte valid mask and the whole page image, which the non-volatile array controller then programs.

Any overrun past eight bytes spoils the transfer. A repeated START, or a STOP that arrives early, drops it without a commit. While the array controller reports an internal write cycle, every event from the bus is ignored. None of the interfaces apply back-pressure. Event strobes and the commit pulse are plain single-cycle signals, and the array controller must take the commit in the cycle it is shown.

Top module: `i2c_page_write_rx`

## Requirements
- R1: During and right after reset, `ack_valid` and `commit_valid` are low and the block waits for a START.
- R2: After START, an address byte whose upper seven bits equal `DEV_ADDR` and whose bit 0 (direction) is 0 is acknowledged. `ack_valid` and `ack_assert` go high in the cycle after the `rx_valid` strobe.
- R3: An address byte with a different address or with bit 0 = 1 gets `ack_valid` = 1 and `ack_assert` = 0. Bytes after it produce no `ack_valid` until the next START.
- R4: The word-address byte, and each of the first eight data bytes, get `ack_assert` = 1.
- R5: Data byte k (counting from 0) goes to page offset (word address bits [2:0] + k) mod 8. The five upper address bits never change. `commit_base` equals the word address with bits [2:0] cleared.
- R6: A STOP after one or more accepted data bytes raises `commit_valid` for exactly one cycle, in the cycle after the `bus_stop` strobe. `commit_mask` bit i is 1 exactly when offset i was written. `commit_data[8i+7:8i]` holds the byte written at offset i.
- R7: The ninth data byte, and every byte after it, gets `ack_valid` = 1 and `ack_assert` = 0. The following STOP produces no commit.
- R8: A STOP right after the address byte or the word-address byte produces no commit.
- R9: A repeated START discards the buffered bytes. A commit that follows shows only the bytes of the new frame.
- R10: While `nvm_busy` is 1, `bus_start`, `bus_stop` and `rx_valid` have no effect: no `ack_valid`, no commit, and the frame state is kept for when `nvm_busy` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | START or repeated START seen (one-cycle strobe) |
| bus_stop | input | 1 | STOP seen (one-cycle strobe) |
| rx_valid | input | 1 | A received byte is present on `rx_byte` (one-cycle strobe) |
| rx_byte | input | 8 | Received byte, MSB first as sent on the bus |
| nvm_busy | input | 1 | Array internal write cycle in progress |
| ack_valid | output | 1 | An acknowledge decision is present, one cycle after `rx_valid` |
| ack_assert | output | 1 | 1 = drive ACK, 0 = leave the slot released |
| commit_valid | output | 1 | One-cycle page programming request |
| commit_base | output | 8 | Page base word address, low three bits zero |
| commit_mask | output | 8 | Bit i set when page offset i holds new data |
| commit_data | output | 64 | Page image, offset i in bits [8i+7:8i] |

## Verification
A wrong frame state shows up on `ack_assert` one cycle after the next byte strobe: a byte that should be refused gets acknowledged, or the reverse. A wrong offset or wrap shows up only at the STOP. In the cycle after it, `commit_mask` and `commit_data` land on the wrong lanes. A lost discard, after an overrun or a repeated START, shows as a stray or stale commit in that same cycle. So each transfer pattern must end in a STOP whose commit is compared lane by lane.

// File: rtl/i2cpw_pkg.sv
package i2cpw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SLA   = 3'd1,
    ST_WADDR = 3'd2,
    ST_DATA  = 3'd3,
    ST_DROP  = 3'd4
  } frame_st_e;
endpackage

// File: rtl/i2cpw_frame_fsm.sv
module i2cpw_frame_fsm
  import i2cpw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'h50,
  parameter int         PAGE_BYTES = 8,
  parameter int         WADDR_W    = 8,
  localparam int        OFF_W      = $clog2(PAGE_BYTES),
  localparam int        HI_W       = WADDR_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_start,
  input  logic             bus_stop,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  input  logic             nvm_busy,
  output logic             ack_valid,
  output logic             ack_assert,
  output logic             buf_clr,
  output logic             buf_wr,
  output logic [OFF_W-1:0] buf_off,
  output logic [HI_W-1:0]  page_hi,
  output logic             commit_fire
);
  localparam int CNT_W = OFF_W + 1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(PAGE_BYTES);

  frame_st_e        st_q, st_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [HI_W-1:0]  hi_q, hi_d;
  logic             av_d, aa_d;
  logic             live;

  assign live = !nvm_busy;

  always_comb begin
    st_d        = st_q;
    off_d       = off_q;
    cnt_d       = cnt_q;
    hi_d        = hi_q;
    av_d        = 1'b0;
    aa_d        = 1'b0;
    buf_clr     = 1'b0;
    buf_wr      = 1'b0;
    commit_fire = 1'b0;
    if (live) begin
      if (bus_stop) begin
        commit_fire = (st_q == ST_DATA) && (cnt_q != '0);
        st_d        = ST_IDLE;
      end else if (bus_start) begin
        st_d    = ST_SLA;
        cnt_d   = '0;
        buf_clr = 1'b1;
      end else if (rx_valid) begin
        unique case (st_q)
          ST_SLA: begin
            av_d = 1'b1;
            if (rx_byte[7:1] == DEV_ADDR && !rx_byte[0]) begin
              aa_d = 1'b1;
              st_d = ST_WADDR;
            end else begin
              st_d = ST_IDLE;
            end
          end
          ST_WADDR: begin
            av_d  = 1'b1;
            aa_d  = 1'b1;
            hi_d  = rx_byte[WADDR_W-1:OFF_W];
            off_d = rx_byte[OFF_W-1:0];
            st_d  = ST_DATA;
          end
          ST_DATA: begin
            av_d = 1'b1;
            if (cnt_q < CNT_FULL) begin
              aa_d   = 1'b1;
              buf_wr = 1'b1;
              off_d  = off_q + OFF_W'(1);
              cnt_d  = cnt_q + CNT_W'(1);
            end else begin
              st_d = ST_DROP;
            end
          end
          ST_DROP: av_d = 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign buf_off = off_q;
  assign page_hi = hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      off_q      <= '0;
      cnt_q      <= '0;
      hi_q       <= '0;
      ack_valid  <= 1'b0;
      ack_assert <= 1'b0;
    end else begin
      st_q       <= st_d;
      off_q      <= off_d;
      cnt_q      <= cnt_d;
      hi_q       <= hi_d;
      ack_valid  <= av_d;
      ack_assert <= aa_d;
    end
  end
endmodule

// File: rtl/i2cpw_page_buf.sv
module i2cpw_page_buf #(
  parameter int  PAGE_BYTES = 8,
  localparam int OFF_W      = $clog2(PAGE_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    wr,
  input  logic [OFF_W-1:0]        off,
  input  logic [7:0]              wdata,
  output logic [PAGE_BYTES-1:0]   mask,
  output logic [PAGE_BYTES*8-1:0] data
);
  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_lane
    logic hit;
    assign hit = wr && (off == OFF_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask[i]        <= 1'b0;
        data[8*i +: 8] <= '0;
      end else if (clr) begin
        mask[i]        <= 1'b0;
        data[8*i +: 8] <= '0;
      end else if (hit) begin
        mask[i]        <= 1'b1;
        data[8*i +: 8] <= wdata;
      end
    end
  end
endmodule

// File: rtl/i2cpw_commit_stage.sv
module i2cpw_commit_stage #(
  parameter int  PAGE_BYTES = 8,
  parameter int  WADDR_W    = 8,
  localparam int OFF_W      = $clog2(PAGE_BYTES),
  localparam int HI_W       = WADDR_W - OFF_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fire,
  input  logic [HI_W-1:0]         page_hi,
  input  logic [PAGE_BYTES-1:0]   buf_mask,
  input  logic [PAGE_BYTES*8-1:0] buf_data,
  output logic                    commit_valid,
  output logic [WADDR_W-1:0]      commit_base,
  output logic [PAGE_BYTES-1:0]   commit_mask,
  output logic [PAGE_BYTES*8-1:0] commit_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_valid <= 1'b0;
      commit_base  <= '0;
      commit_mask  <= '0;
      commit_data  <= '0;
    end else begin
      commit_valid <= fire;
      if (fire) begin
        commit_base <= {page_hi, {OFF_W{1'b0}}};
        commit_mask <= buf_mask;
        commit_data <= buf_data;
      end
    end
  end
endmodule

// File: rtl/i2c_page_write_rx.sv
module i2c_page_write_rx #(
  parameter logic [6:0] DEV_ADDR   = 7'h50,
  parameter int         PAGE_BYTES = 8,
  parameter int         WADDR_W    = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_start,
  input  logic                    bus_stop,
  input  logic                    rx_valid,
  input  logic [7:0]              rx_byte,
  input  logic                    nvm_busy,
  output logic                    ack_valid,
  output logic                    ack_assert,
  output logic                    commit_valid,
  output logic [WADDR_W-1:0]      commit_base,
  output logic [PAGE_BYTES-1:0]   commit_mask,
  output logic [PAGE_BYTES*8-1:0] commit_data
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int HI_W  = WADDR_W - OFF_W;

  logic                    buf_clr, buf_wr, fire;
  logic [OFF_W-1:0]        buf_off;
  logic [HI_W-1:0]         page_hi;
  logic [PAGE_BYTES-1:0]   buf_mask;
  logic [PAGE_BYTES*8-1:0] buf_data;

  i2cpw_frame_fsm #(
    .DEV_ADDR(DEV_ADDR), .PAGE_BYTES(PAGE_BYTES), .WADDR_W(WADDR_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .nvm_busy(nvm_busy),
    .ack_valid(ack_valid), .ack_assert(ack_assert), .buf_clr(buf_clr),
    .buf_wr(buf_wr), .buf_off(buf_off), .page_hi(page_hi), .commit_fire(fire)
  );

  i2cpw_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr(buf_wr), .off(buf_off),
    .wdata(rx_byte), .mask(buf_mask), .data(buf_data)
  );

  i2cpw_commit_stage #(.PAGE_BYTES(PAGE_BYTES), .WADDR_W(WADDR_W)) u_commit (
    .clk(clk), .rst_n(rst_n), .fire(fire), .page_hi(page_hi),
    .buf_mask(buf_mask), .buf_data(buf_data), .commit_valid(commit_valid),
    .commit_base(commit_base), .commit_mask(commit_mask), .commit_data(commit_data)
  );
endmodule

// File: rtl/i2cpw_checker.sv
module i2cpw_checker #(
  parameter int PAGE_BYTES = 8,
  parameter int WADDR_W    = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_stop,
  input logic                  rx_valid,
  input logic                  nvm_busy,
  input logic                  ack_valid,
  input logic                  ack_assert,
  input logic                  commit_valid,
  input logic [WADDR_W-1:0]    commit_base,
  input logic [PAGE_BYTES-1:0] commit_mask
);
  localparam int OFF_W = $clog2(PAGE_BYTES);

  // R2
  ack_follows_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> $past(rx_valid));

  // R2
  ack_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_assert |-> ack_valid);

  // R10
  busy_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> !$past(nvm_busy));

  // R10
  busy_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> !$past(nvm_busy));

  // R6
  commit_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> $past(bus_stop));

  // R6
  commit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |=> !commit_valid);

  // R6
  commit_mask_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> commit_mask != '0);

  // R5
  commit_base_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> commit_base[OFF_W-1:0] == '0);
endmodule

bind i2c_page_write_rx i2cpw_checker #(.PAGE_BYTES(PAGE_BYTES), .WADDR_W(WADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_stop(bus_stop), .rx_valid(rx_valid),
  .nvm_busy(nvm_busy), .ack_valid(ack_valid), .ack_assert(ack_assert),
  .commit_valid(commit_valid), .commit_base(commit_base), .commit_mask(commit_mask)
);

// File: tb/tb_i2c_page_write_rx.sv
`timescale 1ns/1ps
module tb_i2c_page_write_rx;
  localparam logic [7:0] SLA_W = 8'hA0;  // 0x50 with direction bit 0
  localparam int NVEC = 5;
  // {word address, data byte count, expected mask}
  localparam logic [23:0] VEC [NVEC] = '{
    {8'h10, 8'd1, 8'h01},
    {8'h23, 8'd3, 8'h38},
    {8'h46, 8'd4, 8'hC3},
    {8'h58, 8'd8, 8'hFF},
    {8'hFD, 8'd6, 8'hE7}
  };

  logic clk = 0, rst_n = 0;
  logic bus_start = 0, bus_stop = 0, rx_valid = 0, nvm_busy = 0;
  logic [7:0] rx_byte = 0;
  logic ack_valid, ack_assert, commit_valid;
  logic [7:0] commit_base, commit_mask;
  logic [63:0] commit_data;

  int total = 0, fails = 0;
  logic got_av, got_aa, cv, cv_next;
  logic [7:0] cb, cm;
  logic [63:0] cd;

  always #2 clk = ~clk;

  i2c_page_write_rx dut (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .nvm_busy(nvm_busy),
    .ack_valid(ack_valid), .ack_assert(ack_assert), .commit_valid(commit_valid),
    .commit_base(commit_base), .commit_mask(commit_mask), .commit_data(commit_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] val(input logic [7:0] wa, input int k);
    return wa ^ 8'(k * 29 + 90);
  endfunction

  task automatic do_start();
    @(negedge clk); bus_start = 1;
    @(negedge clk); bus_start = 0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_byte = b;
    @(negedge clk); rx_valid = 0;
    got_av = ack_valid; got_aa = ack_assert;
  endtask

  task automatic do_stop();
    @(negedge clk); bus_stop = 1;
    @(negedge clk); bus_stop = 0;
    cv = commit_valid; cb = commit_base; cm = commit_mask; cd = commit_data;
    @(negedge clk); cv_next = commit_valid;
  endtask

  initial begin
    #(4 * 200000);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [63:0] exp_d;
    int bad_acks;
    repeat (3) @(negedge clk);
    chk("R1 ack_valid in reset", 64'(ack_valid), 0);
    chk("R1 commit in reset", 64'(commit_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ack_valid after reset", 64'(ack_valid), 0);
    send(8'h11);
    chk("R1 byte before START ignored", 64'(got_av), 0);

    // table-driven page writes
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] wa, n, em;
      {wa, n, em} = VEC[v];
      bad_acks = 0;
      exp_d = '0;
      do_start();
      send(SLA_W);
      chk("R2 address ack", {62'd0, got_av, got_aa}, 64'd3);
      send(wa);
      chk("R4 word address ack", {62'd0, got_av, got_aa}, 64'd3);
      for (int k = 0; k < int'(n); k++) begin
        send(val(wa, k));
        if (!(got_av && got_aa)) bad_acks++;
        exp_d[8 * ((int'(wa) + k) % 8) +: 8] = val(wa, k);
      end
      chk("R4 data acks", 64'(bad_acks), 0);
      do_stop();
      chk("R6 commit pulse", 64'(cv), 1);
      chk("R6 commit one cycle", 64'(cv_next), 0);
      chk("R5 commit base", 64'(cb), 64'(wa & 8'hF8));
      chk("R5 wrap mask", 64'(cm), 64'(em));
      chk("R6 commit data", cd, exp_d);
    end

    // R3: wrong device address
    do_start();
    send(8'hA2);
    chk("R3 mismatch not acked", {62'd0, got_av, got_aa}, 64'd2);
    send(8'h05);
    chk("R3 later byte silent", 64'(got_av), 0);
    do_stop();
    chk("R3 no commit", 64'(cv), 0);

    // R3: read direction
    do_start();
    send(SLA_W | 8'h01);
    chk("R3 read bit not acked", {62'd0, got_av, got_aa}, 64'd2);
    do_stop();
    chk("R3 read no commit", 64'(cv), 0);

    // R7: nine data bytes
    do_start(); send(SLA_W); send(8'h30);
    for (int k = 0; k < 8; k++) send(8'(k));
    send(8'hEE);
    chk("R7 ninth byte refused", {62'd0, got_av, got_aa}, 64'd2);
    send(8'hEF);
    chk("R7 tenth byte refused", {62'd0, got_av, got_aa}, 64'd2);
    do_stop();
    chk("R7 no commit after overrun", 64'(cv), 0);

    // R8: early STOPs
    do_start(); send(SLA_W);
    do_stop();
    chk("R8 stop after address", 64'(cv), 0);
    do_start(); send(SLA_W); send(8'h40);
    do_stop();
    chk("R8 stop after word address", 64'(cv), 0);

    // R9: repeated START discards earlier bytes
    do_start(); send(SLA_W); send(8'h60); send(8'hAA); send(8'hBB);
    do_start(); send(SLA_W); send(8'h64); send(8'hCC);
    do_stop();
    chk("R9 commit after restart", 64'(cv), 1);
    chk("R9 mask only new", 64'(cm), 64'h10);
    chk("R9 data only new", cd, 64'h0000_00CC_0000_0000);

    // R10: busy freezes the frame
    do_start(); send(SLA_W); send(8'h80); send(8'h11);
    nvm_busy = 1;
    send(8'h22);
    chk("R10 no ack while busy", 64'(got_av), 0);
    do_stop();
    chk("R10 stop ignored while busy", 64'(cv), 0);
    do_start();
    nvm_busy = 0;
    send(8'h33);
    chk("R10 frame kept", {62'd0, got_av, got_aa}, 64'd3);
    do_stop();
    chk("R10 commit after busy", 64'(cv), 1);
    chk("R10 mask", 64'(cm), 64'h03);
    chk("R10 data", cd, 64'h0000_0000_0000_3311);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule